// File: doc/BRIEF.md
# Byte-Granular DMA Engine for a Word-Only Memory Bus

This engine moves a run of bytes between a byte stream and a memory that can only be read or written a whole 16-bit word at a time. A requester gives a byte start address, a signed byte count and a direction, then pulses `start`. In the store direction, bytes are taken from an input valid/ready stream and packed into words. In the load direction, words are fetched and unpacked onto an output valid/ready stream. Byte lanes are little-endian: bit 0 of the byte address picks the lane, with the even byte in bits 7:0 of the word.

There are no byte strobes on the bus. When a store starts on an odd address, or ends with a single leftover byte, the engine fetches the word, merges the new byte into the correct lane, and writes the word back. Whole byte pairs go out as plain word writes. In the load direction, an odd start delivers only the upper byte of the first word, and a single trailing byte delivers only the lower byte of the last word. An error response on any bus beat ends the transfer at once, and `err` reports it with `done`.

The controller has ten states:
- `ST_IDLE` goes to `ST_NEXT` when `start` is seen.
- `ST_NEXT` is the dispatch point. It goes to `ST_FINISH` when no bytes remain. A load goes to `ST_R_FETCH`. A store goes to `ST_W_FETCH` when the address is odd or one byte remains, and to `ST_W_TAKE_LO` otherwise.
- `ST_W_FETCH` goes to `ST_W_TAKE_HI` (odd address) or `ST_W_TAKE_LO` (even address) on a good response.
- `ST_W_TAKE_LO` goes to `ST_W_STORE` for a merge, or to `ST_W_TAKE_HI` for a pair.
- `ST_W_TAKE_HI` goes to `ST_W_STORE`.
- `ST_W_STORE` goes back to `ST_NEXT` on a good response.
- `ST_R_FETCH` goes to `ST_R_EMIT_HI` (odd address) or `ST_R_EMIT_LO`.
- `ST_R_EMIT_LO` goes to `ST_NEXT` when it was the last byte, and to `ST_R_EMIT_HI` otherwise.
- `ST_R_EMIT_HI` goes to `ST_NEXT`.
- Any error response goes to `ST_FINISH`, and `ST_FINISH` returns to `ST_IDLE`.

Top module: `byte_dma_engine`

## Requirements
- R1: In a store, a byte at an even address lands in bits 7:0 of its word and the following byte in bits 15:8. A pair of bytes is written as one full word with no preceding read. Every byte offered is consumed.
- R2: A store beginning at an odd address first reads the word at (address-1). It keeps bits 7:0 of that word, places the first byte in bits 15:8, and writes the word back to (address-1).
- R3: When a single store byte remains at an even address, the engine reads that word, keeps bits 15:8, places the byte in bits 7:0, and writes the word back.
- R4: `bus_addr` bit 0 is always 0, and the word address advances by 2 after each stored pair. The number of word writes in a store equals head + pairs + tail.
- R5: A load beginning at an odd address delivers only bits 15:8 of the first word as its first byte.
- R6: A load delivers bits 7:0 and then bits 15:8 of each word. With one byte left, it delivers only bits 7:0 of the last word. Exactly max(length,0) bytes come out, and each word touched is read once.
- R7: A response with `bus_err`=1 ends the transfer at once: no further bus request is made, `done` follows in the next cycle, and `err`=1 is held until the next accepted start. A clean transfer ends with `err`=0.
- R8: A length of zero or less completes, with `done` two cycles after start, with no bus request and `err`=0.
- R9: `busy` is 1 from the cycle after an accepted start through the `done` cycle, and 0 otherwise. A `start` while busy is ignored.
- R10: A bus request holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` unchanged until `bus_ack`.
- R11: `in_ready` is only raised in the store direction (`start_rd`=0), and `out_valid` only in the load direction (`start_rd`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| start_rd | input | 1 | 1 = memory to output stream, 0 = input stream to memory |
| start_addr | input | ADDR_W | Byte start address |
| start_len | input | LEN_W | Signed byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer ended on a bus error |
| in_valid | input | 1 | Store byte offered |
| in_data | input | BYTE_W | Store byte |
| in_ready | output | 1 | Store byte accepted when valid |
| out_valid | output | 1 | Load byte offered |
| out_data | output | BYTE_W | Load byte |
| out_ready | input | 1 | Load byte taken when valid |
| bus_req | output | 1 | Word request |
| bus_we | output | 1 | 1 = word write, 0 = word read |
| bus_addr | output | ADDR_W | Byte address of the word, bit 0 zero |
| bus_wdata | output | 2*BYTE_W | Write word |
| bus_ack | input | 1 | Response for the current request |
| bus_rdata | input | 2*BYTE_W | Read word, valid with `bus_ack` |
| bus_err | input | 1 | Error flag, valid with `bus_ack` |

## Verification
Two things can land in the same cycle. A bus error can arrive on a read-modify-write beat while the head merge is half built, and a new `start` can arrive while a transfer is still running. The bench forces an error on a chosen beat of an odd-start store and of a load. It then judges the beat count, the bytes moved, the untouched memory image and the `err` flag. It also pulses a load `start` in the middle of a store, and requires the store's memory image to be exact, no stray word reads, and no output-stream activity.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NEXT,
        ST_W_FETCH,
        ST_W_TAKE_LO,
        ST_W_TAKE_HI,
        ST_W_STORE,
        ST_R_FETCH,
        ST_R_EMIT_LO,
        ST_R_EMIT_HI,
        ST_FINISH
    } bdma_state_t;

    localparam int unsigned LANE_COUNT = 2;

endpackage

// File: rtl/bdma_cursor.sv
module bdma_cursor #(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic [LEN_W-1:0]        load_len,
    input  logic                    step,
    input  logic                    step_two,
    output logic [ADDR_W-1:0]       addr,
    output logic                    empty,
    output logic                    last
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_TWO = ADDR_W'(2);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0]  LEN_TWO  = LEN_W'(2);

    logic [ADDR_W-1:0]        addr_q;
    logic signed [LEN_W-1:0]  remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= $signed(load_len);
        end else if (step) begin
            addr_q   <= addr_q + (step_two ? ADDR_TWO : ADDR_ONE);
            remain_q <= remain_q - $signed(step_two ? LEN_TWO : LEN_ONE);
        end
    end

    assign addr  = addr_q;
    assign empty = (remain_q <= 0);
    assign last  = (remain_q == 1);

    AST_REMAIN_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (remain_q < $past(remain_q))); // R4

endmodule

// File: rtl/bdma_wpack.sv
module bdma_wpack #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill,
    input  logic [2*BYTE_W-1:0]   fill_word,
    input  logic                  put,
    input  logic                  put_lane,
    input  logic [BYTE_W-1:0]     put_byte,
    output logic [2*BYTE_W-1:0]   word
);
    localparam int LANES = bdma_pkg::LANE_COUNT;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (fill) begin
                lane_q <= fill_word[g*BYTE_W +: BYTE_W];
            end else if (put && (put_lane == 1'(g))) begin
                lane_q <= put_byte;
            end
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end

    AST_LOW_PUT_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !fill && !put_lane) |=> (word[2*BYTE_W-1:BYTE_W] == $past(word[2*BYTE_W-1:BYTE_W]))); // R3
    AST_HIGH_PUT_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !fill && put_lane) |=> (word[BYTE_W-1:0] == $past(word[BYTE_W-1:0]))); // R2

endmodule

// File: rtl/bdma_rpick.sv
module bdma_rpick #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [2*BYTE_W-1:0]   cap_word,
    input  logic                  sel_hi,
    output logic [BYTE_W-1:0]     byte_out
);
    logic [2*BYTE_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= cap_word;
        end
    end

    assign byte_out = sel_hi ? word_q[2*BYTE_W-1:BYTE_W] : word_q[BYTE_W-1:0];

endmodule

// File: rtl/byte_dma_engine.sv
module byte_dma_engine
    import bdma_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_rd,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [LEN_W-1:0]      start_len,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [BYTE_W-1:0]     out_data,
    input  logic                  out_ready,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [2*BYTE_W-1:0]   bus_wdata,
    input  logic                  bus_ack,
    input  logic [2*BYTE_W-1:0]   bus_rdata,
    input  logic                  bus_err
);
    localparam int WORD_W = 2 * BYTE_W;

    bdma_state_t state_q, state_d;
    logic        dir_rd_q;
    logic        rmw_q;
    logic        err_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_empty;
    logic              cur_last;
    logic              cur_step;
    logic              cur_step_two;
    logic              accept;
    logic              bus_ok;
    logic              bus_fail;
    logic              in_hs;
    logic              out_hs;
    logic [WORD_W-1:0] pack_word;
    logic [BYTE_W-1:0] pick_byte;

    assign accept   = (state_q == ST_IDLE) && start;
    assign bus_ok   = bus_req && bus_ack && !bus_err;
    assign bus_fail = bus_req && bus_ack && bus_err;
    assign in_hs    = in_valid && in_ready;
    assign out_hs   = out_valid && out_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_NEXT;
            end
            ST_NEXT: begin
                if (cur_empty)                   state_d = ST_FINISH;
                else if (dir_rd_q)               state_d = ST_R_FETCH;
                else if (cur_addr[0] || cur_last) state_d = ST_W_FETCH;
                else                             state_d = ST_W_TAKE_LO;
            end
            ST_W_FETCH: begin
                if (bus_fail)    state_d = ST_FINISH;
                else if (bus_ok) state_d = cur_addr[0] ? ST_W_TAKE_HI : ST_W_TAKE_LO;
            end
            ST_W_TAKE_LO: begin
                if (in_hs) state_d = rmw_q ? ST_W_STORE : ST_W_TAKE_HI;
            end
            ST_W_TAKE_HI: begin
                if (in_hs) state_d = ST_W_STORE;
            end
            ST_W_STORE: begin
                if (bus_fail)    state_d = ST_FINISH;
                else if (bus_ok) state_d = ST_NEXT;
            end
            ST_R_FETCH: begin
                if (bus_fail)    state_d = ST_FINISH;
                else if (bus_ok) state_d = cur_addr[0] ? ST_R_EMIT_HI : ST_R_EMIT_LO;
            end
            ST_R_EMIT_LO: begin
                if (out_hs) state_d = cur_last ? ST_NEXT : ST_R_EMIT_HI;
            end
            ST_R_EMIT_HI: begin
                if (out_hs) state_d = ST_NEXT;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- control registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_rd_q <= 1'b0;
            rmw_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (accept) begin
                dir_rd_q <= start_rd;
                err_q    <= 1'b0;
            end
            if (state_q == ST_NEXT) begin
                rmw_q <= cur_addr[0] || cur_last;
            end
            if (bus_fail) begin
                err_q <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        bus_req   = (state_q == ST_W_FETCH) || (state_q == ST_W_STORE) || (state_q == ST_R_FETCH);
        bus_we    = (state_q == ST_W_STORE);
        in_ready  = (state_q == ST_W_TAKE_LO) || (state_q == ST_W_TAKE_HI);
        out_valid = (state_q == ST_R_EMIT_LO) || (state_q == ST_R_EMIT_HI);
        bus_addr  = {cur_addr[ADDR_W-1:1], 1'b0};
        bus_wdata = pack_word;
        out_data  = pick_byte;
        err       = err_q;
    end

    assign cur_step     = ((state_q == ST_W_STORE) && bus_ok) || out_hs;
    assign cur_step_two = (state_q == ST_W_STORE) && !rmw_q;

    bdma_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (start_addr),
        .load_len  (start_len),
        .step      (cur_step),
        .step_two  (cur_step_two),
        .addr      (cur_addr),
        .empty     (cur_empty),
        .last      (cur_last)
    );

    bdma_wpack #(
        .BYTE_W (BYTE_W)
    ) u_wpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      ((state_q == ST_W_FETCH) && bus_ok),
        .fill_word (bus_rdata),
        .put       (in_hs),
        .put_lane  (state_q == ST_W_TAKE_HI),
        .put_byte  (in_data),
        .word      (pack_word)
    );

    bdma_rpick #(
        .BYTE_W (BYTE_W)
    ) u_rpick (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  ((state_q == ST_R_FETCH) && bus_ok),
        .cap_word (bus_rdata),
        .sel_hi   (state_q == ST_R_EMIT_HI),
        .byte_out (pick_byte)
    );

    // ---------------- assertions ----------------
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R10
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !bus_addr[0]); // R4
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_err) |=> (done && !bus_req && err)); // R7
    AST_EMPTY_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ($signed(start_len) <= 0)) |=> (!bus_req ##1 (done && !bus_req))); // R8
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9
    AST_ODD_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack && !bus_err && dir_rd_q && cur_addr[0])
        |=> (out_valid && (out_data == $past(bus_rdata[WORD_W-1:BYTE_W])))); // R5
    AST_EVEN_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack && !bus_err && dir_rd_q && !cur_addr[0])
        |=> (out_valid && (out_data == $past(bus_rdata[BYTE_W-1:0])))); // R6
    AST_STREAM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready |-> !dir_rd_q) and (out_valid |-> dir_rd_q)); // R11

endmodule

// File: tb/byte_dma_engine_tb.sv
module byte_dma_engine_tb;
    localparam int ADDR_W = 18;
    localparam int LEN_W  = 16;
    localparam int BYTE_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_rd = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic        busy, done, err;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_err = 1'b0;

    byte_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .start_addr(start_addr), .start_len(start_len),
        .busy(busy), .done(done), .err(err),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int ncyc = 0;

    logic [15:0] mem_w [16];
    logic [15:0] old_w [16];
    logic [7:0]  got   [16];

    int run_id = 0;
    int lat = 0;
    int err_beat = 0;
    int beats = 0, rd_n = 0, wr_n = 0;
    int addr_bad = 0, hold_bad = 0, dir_bad = 0;
    int wait_n = 0;
    logic [ADDR_W-1:0] seen_addr = '0;
    logic seen_we = 1'b0;
    int in_idx = 0, in_len = 0;
    bit in_hs = 1'b0;
    int got_n = 0;
    bit xfer_rd = 1'b0;
    bit r_err = 1'b0;

    function automatic logic [7:0] wbyte(input int r, input int k);
        return 8'(r * 7 + k * 13 + 5);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (run %0d)", tag, act, exp, run_id);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            ncyc++;
            if (ncyc > 150000) begin
                miscompares++;
                $display("FAIL watchdog R9 actual=%0d expected<150000 cycles", ncyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    // bus responder and stream agents, acting on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
            end else if (bus_req) begin
                if (wait_n == 0) begin
                    seen_addr = bus_addr;
                    seen_we   = bus_we;
                end
                if (wait_n < lat) begin
                    wait_n++;
                end else begin
                    wait_n = 0;
                    beats++;
                    if (bus_addr != seen_addr || bus_we != seen_we) hold_bad++;
                    if (bus_addr[0] || bus_addr >= ADDR_W'(32)) addr_bad++;
                    if (beats == err_beat) begin
                        bus_err = 1'b1;
                    end else if (bus_we) begin
                        mem_w[bus_addr[4:1]] = bus_wdata;
                        wr_n++;
                    end else begin
                        bus_rdata = mem_w[bus_addr[4:1]];
                        rd_n++;
                    end
                    bus_ack = 1'b1;
                end
            end
            if (in_hs) in_idx++;
            in_valid = !xfer_rd && (in_idx < in_len) && (((ncyc + run_id) % 4) != 3);
            in_data  = wbyte(run_id, in_idx);
            in_hs    = in_valid && in_ready;
            out_ready = ((ncyc + run_id) % 5) != 2;
            if (out_valid && out_ready) begin
                if (got_n < 16) got[got_n] = out_data;
                got_n++;
            end
            if ((xfer_rd && in_ready) || (!xfer_rd && out_valid)) dir_bad++;
        end
    end

    task automatic run_xfer(input bit rd, input int sa, input int ln, input int eb, input int poke);
        int waited;
        @(posedge clk); #5;
        run_id++;
        lat = run_id % 3;
        err_beat = eb;
        beats = 0; rd_n = 0; wr_n = 0;
        addr_bad = 0; hold_bad = 0; dir_bad = 0; wait_n = 0;
        in_idx = 0; in_hs = 1'b0; got_n = 0;
        in_len = rd ? 0 : (ln > 0 ? ln : 0);
        xfer_rd = rd;
        for (int i = 0; i < 16; i++) begin
            mem_w[i] = 16'((i * 16'h1357) ^ (run_id * 16'h0101) ^ 16'hA5C3);
            old_w[i] = mem_w[i];
        end
        start = 1'b1; start_rd = rd;
        start_addr = ADDR_W'(sa); start_len = LEN_W'(ln);
        @(posedge clk); #5;
        start = 1'b0;
        chk("R9 busy after start", int'(busy), 1);
        waited = 0;
        while (!done) begin
            @(posedge clk); #5;
            waited++;
            if (poke > 0 && waited == poke) begin
                chk("R9 busy when second start", int'(busy), 1);
                start = 1'b1; start_rd = 1'b1;
                start_addr = ADDR_W'(10); start_len = LEN_W'(4);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        r_err = err;
        @(posedge clk); #5;
        chk("R9 idle after done", int'(busy), 0);
        @(posedge clk); #5;
        in_len = 0;
    endtask

    task automatic check_store(input int sa, input int ln);
        int head, rem, exp_rd, exp_wr, mism;
        string tag;
        head = (ln > 0 && (sa % 2) == 1) ? 1 : 0;
        rem  = (ln > 0) ? ln - head : 0;
        exp_rd = head + (rem % 2);
        exp_wr = head + rem / 2 + (rem % 2);
        tag = (sa % 2 == 1) ? "R2 store image" : ((ln % 2 == 1) ? "R3 store image" : "R1 store image");
        mism = 0;
        for (int w = 0; w < 16; w++) begin
            logic [15:0] e;
            e = old_w[w];
            for (int b = 0; b < 2; b++) begin
                int a;
                a = 2 * w + b;
                if (a >= sa && a < sa + ln) e[b*8 +: 8] = wbyte(run_id, a - sa);
            end
            if (e != mem_w[w]) begin
                mism++;
                chk(tag, int'(mem_w[w]), int'(e));
            end
        end
        if (mism == 0) chk(tag, 0, 0);
        chk((sa % 2 == 1) ? "R2 merge reads" : "R3 merge reads", rd_n, exp_rd);
        chk("R4 word writes", wr_n, exp_wr);
        chk("R4 address bit0/range", addr_bad, 0);
        chk("R10 request held", hold_bad, 0);
        chk("R1 bytes consumed", in_idx, ln > 0 ? ln : 0);
        chk("R11 stream side", dir_bad, 0);
        chk("R7 clean err", int'(r_err), 0);
        if (ln <= 0) chk("R8 no bus beats", beats, 0);
    endtask

    task automatic check_load(input int sa, input int ln);
        int exp_n, exp_rd;
        exp_n  = ln > 0 ? ln : 0;
        exp_rd = ln > 0 ? (((sa + ln - 1) >> 1) - (sa >> 1) + 1) : 0;
        chk("R6 byte count", got_n, exp_n);
        chk("R6 word reads", rd_n, exp_rd);
        chk("R6 no writes", wr_n, 0);
        for (int i = 0; i < exp_n && i < 16; i++) begin
            int a;
            a = sa + i;
            chk((i == 0 && (sa % 2) == 1) ? "R5 odd first byte" : "R6 load byte",
                int'(got[i]), int'(old_w[a >> 1][(a % 2) * 8 +: 8]));
        end
        chk("R4 address bit0/range", addr_bad, 0);
        chk("R10 request held", hold_bad, 0);
        chk("R11 stream side", dir_bad, 0);
        chk("R7 clean err", int'(r_err), 0);
        if (ln <= 0) chk("R8 no bus beats", beats, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R7 reset err", int'(err), 0);
        chk("R10 reset bus_req", int'(bus_req), 0);
        rst_n = 1'b1;

        for (int d = 0; d < 2; d++) begin
            for (int sa = 0; sa < 8; sa++) begin
                for (int ln = -1; ln <= 9; ln++) begin
                    run_xfer(d == 1, sa, ln, 0, 0);
                    if (d == 1) check_load(sa, ln);
                    else        check_store(sa, ln);
                end
            end
        end

        // start pulse in the middle of a store must be ignored
        run_xfer(1'b0, 2, 4, 0, 3);
        check_store(2, 4);

        // error on the write-back of an odd-start merge
        run_xfer(1'b0, 1, 6, 2, 0);
        chk("R7 store err flag", int'(r_err), 1);
        chk("R7 store beats stop", beats, 2);
        chk("R7 store bytes taken", in_idx, 1);
        for (int w = 0; w < 16; w++) chk("R7 store memory untouched", int'(mem_w[w]), int'(old_w[w]));

        // error on the second fetch of a load
        run_xfer(1'b1, 0, 6, 2, 0);
        chk("R7 load err flag", int'(r_err), 1);
        chk("R7 load beats stop", beats, 2);
        chk("R7 load bytes out", got_n, 2);
        chk("R7 err held after done", int'(err), 1);

        // error on the very first beat of a pair store
        run_xfer(1'b0, 4, 2, 1, 0);
        chk("R7 first beat err", int'(r_err), 1);
        chk("R7 first beat count", beats, 1);

        // the next clean start clears the flag
        run_xfer(1'b0, 0, 2, 0, 0);
        check_store(0, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule